// File: doc/BRIEF.md
# On-Screen Display Pixel Compositor

This block takes the dot-by-dot result of a character generator and turns it into the colour and control outputs of an on-screen display overlay. For each dot clock it receives the foreground bit of the current dot and the foreground bits of the nearby dots. It also receives the palette slot of the character cell under the beam, the four-entry colour palette of the current text row, the beam position and the register set of three rectangular background windows. From these it selects one colour and drives the R, G and B lines. It also drives a fast-blank line, which tells the monitor to switch to the overlay, and a half-tone line, which dims the video behind transparent windows.

The highest-priority source on a dot is the character foreground. Next comes a black outline around the glyph. This outline is either a full border or a drop shadow, and a control bit picks which. After that come the windows, and among overlapping windows the one with the lowest index wins. A dot with none of these is transparent. Every output has its own enable for an external tristate pad. The colour and half-tone enables follow the display enable. The fast-blank enable is high only while something is drawn. The result is registered in two stages.

Top module: `osd_compositor`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, every output and every output enable is low.
- R2: Each output reflects the inputs sampled two rising clock edges earlier, with no gaps when the inputs change every cycle.
- R3: When `osdEn` was low, `colOe`, `fbkgOe` and `htoneOe` are low and `colOut`, `fbkgOut`, `htoneOut` are zero.
- R4: On a foreground dot (`fgCur`=1) the colour is palette slot k = `cellPalIdx`, taken from `rowPal[3k+2:3k]`. The colour bits are ordered bit 0 = R, bit 1 = G, bit 2 = B. Fast-blank is high and half-tone is low.
- R5: In border mode (`edgeEn`=1, `edgeShadow`=0), a background dot where any of `fgNbr[0]` (left), `fgNbr[1]` (right), `fgNbr[2]` (above) or `fgNbr[3]` (below) is set is drawn black. Fast-blank is driven high and half-tone is low, even inside a window.
- R6: In shadow mode (`edgeShadow`=1), only `fgNbr[4]` (upper-left) makes a background dot black. The four direct neighbours have no effect. In border mode `fgNbr[4]` has no effect.
- R7: With `edgeEn`=0, the neighbour bits have no effect on any output.
- R8: Window i covers rows `winStartRow[i]`..`winEndRow[i]` and columns `winStartCol[i]`..`winEndCol[i]`, both bounds included. Field i sits in slice [i*W +: W] of each vector, and its colour is `winColor[3i+2:3i]`.
- R9: Where enabled windows overlap, the colour of the window with the lowest index is used.
- R10: `htoneOut` is high on window dots that are neither foreground nor outline, and low on all other dots.
- R11: With `fbkgCharOnly`=0, `fbkgOut` is high on foreground, outline and window dots. With `fbkgCharOnly`=1, it is high on foreground and outline dots and low on window-only dots, which are still driven.
- R12: On a transparent dot, `fbkgOe` is low, `colOut` is 000 and `htoneOut` is low, while `colOe` stays high.
- R13: A window whose `winEnable` bit is low does not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| osdEn | input | 1 | Display enable |
| fbkgCharOnly | input | 1 | Fast-blank on character dots only |
| edgeEn | input | 1 | Outline enable |
| edgeShadow | input | 1 | 1 = shadow outline, 0 = border outline |
| beamRow | input | ROW_W | Current line of the beam |
| beamCol | input | COL_W | Current dot column of the beam |
| fgCur | input | 1 | Foreground bit of the current dot |
| fgNbr | input | 5 | Neighbour bits: left, right, above, below, upper-left |
| rowPal | input | NUM_PAL*3 | Colour palette of the current text row |
| cellPalIdx | input | PAL_IDX_W | Palette slot of the current cell |
| winEnable | input | NUM_WIN | Per-window enable |
| winStartRow | input | NUM_WIN*ROW_W | First row of each window |
| winEndRow | input | NUM_WIN*ROW_W | Last row of each window |
| winStartCol | input | NUM_WIN*COL_W | First column of each window |
| winEndCol | input | NUM_WIN*COL_W | Last column of each window |
| winColor | input | NUM_WIN*3 | Colour of each window |
| colOut | output | 3 | R, G, B levels (bit 0 = R) |
| colOe | output | 3 | Tristate enables for R, G, B |
| fbkgOut | output | 1 | Fast-blank level |
| fbkgOe | output | 1 | Fast-blank tristate enable |
| htoneOut | output | 1 | Half-tone level |
| htoneOe | output | 1 | Half-tone tristate enable |

## Verification
Every output of this block is due exactly two rising edges after the inputs it depends on. The first edge classifies the dot and chooses its colour, and the second applies the display enable and the fast-blank mode. The driver changes inputs on a falling edge and tags each expected item with the cycle number two edges later. The monitor compares on the falling edge of that cycle, so both sides stay off the active edge. Runs in which the inputs change on every cycle show at once any stage that is missing or doubled.

// File: rtl/osd_pkg.sv
package osd_pkg;

  localparam int COLOR_W = 3;
  localparam int NBR_N   = 5;

  // neighbour bit positions inside fgNbr
  localparam int NBR_LEFT    = 0;
  localparam int NBR_RIGHT   = 1;
  localparam int NBR_UP      = 2;
  localparam int NBR_DOWN    = 3;
  localparam int NBR_UPLEFT  = 4;

  typedef enum logic [1:0] {
    PIX_NONE = 2'd0,
    PIX_WIN  = 2'd1,
    PIX_EDGE = 2'd2,
    PIX_FG   = 2'd3
  } pixClass_t;

  typedef struct packed {
    logic osdOn;
    logic fbkgCharOnly;
    logic edgeOn;
    logic shadowMode;
  } ctrlStrobe_t;

endpackage

// File: rtl/osd_win_match.sv
module osd_win_match
  import osd_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int ROW_W   = 9,
  parameter int COL_W   = 9
) (
  input  logic [ROW_W-1:0]           beamRow,
  input  logic [COL_W-1:0]           beamCol,
  input  logic [NUM_WIN-1:0]         winEnable,
  input  logic [NUM_WIN*ROW_W-1:0]   winStartRow,
  input  logic [NUM_WIN*ROW_W-1:0]   winEndRow,
  input  logic [NUM_WIN*COL_W-1:0]   winStartCol,
  input  logic [NUM_WIN*COL_W-1:0]   winEndCol,
  input  logic [NUM_WIN*COLOR_W-1:0] winColor,
  output logic                       winAny,
  output logic [COLOR_W-1:0]         winCol
);

  logic [NUM_WIN-1:0] hit;

  // one inclusive rectangle compare per window
  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    logic [ROW_W-1:0] rowLo, rowHi;
    logic [COL_W-1:0] colLo, colHi;
    logic rowIn, colIn;
    assign rowLo = winStartRow[gi*ROW_W +: ROW_W];
    assign rowHi = winEndRow[gi*ROW_W +: ROW_W];
    assign colLo = winStartCol[gi*COL_W +: COL_W];
    assign colHi = winEndCol[gi*COL_W +: COL_W];
    assign rowIn = (beamRow >= rowLo) && (beamRow <= rowHi);
    assign colIn = (beamCol >= colLo) && (beamCol <= colHi);
    assign hit[gi] = winEnable[gi] && rowIn && colIn;
  end

  // lowest index wins: scan from the top, later (lower) hits overwrite
  always_comb begin
    winAny = |hit;
    winCol = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) winCol = winColor[i*COLOR_W +: COLOR_W];
    end
  end

endmodule

// File: rtl/osd_ctrl.sv
module osd_ctrl
  import osd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        osdEn,
  input  logic        fbkgCharOnly,
  input  logic        edgeEn,
  input  logic        edgeShadow,
  output ctrlStrobe_t stNow,
  output ctrlStrobe_t stLate
);

  // strobes used by the classify stage, same cycle as the dot
  always_comb begin
    stNow.osdOn        = osdEn;
    stNow.fbkgCharOnly = fbkgCharOnly;
    stNow.edgeOn       = edgeEn;
    stNow.shadowMode   = edgeShadow;
  end

  // strobes aligned with the registered dot class for the output stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stLate <= '0;
    else       stLate <= stNow;
  end

endmodule

// File: rtl/osd_datapath.sv
module osd_datapath
  import osd_pkg::*;
#(
  parameter int NUM_PAL   = 4,
  parameter int PAL_IDX_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                stNow,
  input  ctrlStrobe_t                stLate,
  input  logic                       fgCur,
  input  logic [NBR_N-1:0]           fgNbr,
  input  logic [NUM_PAL*COLOR_W-1:0] rowPal,
  input  logic [PAL_IDX_W-1:0]       cellPalIdx,
  input  logic                       winAny,
  input  logic [COLOR_W-1:0]         winCol,
  output logic [COLOR_W-1:0]         colOut,
  output logic [COLOR_W-1:0]         colOe,
  output logic                       fbkgOut,
  output logic                       fbkgOe,
  output logic                       htoneOut,
  output logic                       htoneOe
);

  logic borderNear, shadowNear, edgeDot;
  logic [COLOR_W-1:0] fgColor;
  pixClass_t clsD, clsQ;
  logic [COLOR_W-1:0] colD, colQ;

  assign borderNear = fgNbr[NBR_LEFT] | fgNbr[NBR_RIGHT] |
                      fgNbr[NBR_UP]   | fgNbr[NBR_DOWN];
  assign shadowNear = fgNbr[NBR_UPLEFT];
  assign edgeDot    = !fgCur && stNow.edgeOn &&
                      (stNow.shadowMode ? shadowNear : borderNear);
  assign fgColor    = rowPal[int'(cellPalIdx)*COLOR_W +: COLOR_W];

  // stage 1: priority classification and colour pick
  always_comb begin
    if (fgCur) begin
      clsD = PIX_FG;
      colD = fgColor;
    end else if (edgeDot) begin
      clsD = PIX_EDGE;
      colD = '0;
    end else if (winAny) begin
      clsD = PIX_WIN;
      colD = winCol;
    end else begin
      clsD = PIX_NONE;
      colD = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clsQ <= PIX_NONE;
      colQ <= '0;
    end else begin
      clsQ <= clsD;
      colQ <= colD;
    end
  end

  // stage 2: output drive and tristate control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colOut   <= '0;
      colOe    <= '0;
      fbkgOut  <= 1'b0;
      fbkgOe   <= 1'b0;
      htoneOut <= 1'b0;
      htoneOe  <= 1'b0;
    end else if (!stLate.osdOn) begin
      colOut   <= '0;
      colOe    <= '0;
      fbkgOut  <= 1'b0;
      fbkgOe   <= 1'b0;
      htoneOut <= 1'b0;
      htoneOe  <= 1'b0;
    end else begin
      colOut   <= colQ;
      colOe    <= '1;
      htoneOe  <= 1'b1;
      htoneOut <= (clsQ == PIX_WIN);
      fbkgOe   <= (clsQ != PIX_NONE);
      fbkgOut  <= (clsQ == PIX_FG) || (clsQ == PIX_EDGE) ||
                  ((clsQ == PIX_WIN) && !stLate.fbkgCharOnly);
    end
  end

endmodule

// File: rtl/osd_compositor.sv
module osd_compositor
  import osd_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int ROW_W   = 9,
  parameter int COL_W   = 9,
  parameter int NUM_PAL = 4,
  localparam int PAL_IDX_W = (NUM_PAL > 1) ? $clog2(NUM_PAL) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       osdEn,
  input  logic                       fbkgCharOnly,
  input  logic                       edgeEn,
  input  logic                       edgeShadow,
  input  logic [ROW_W-1:0]           beamRow,
  input  logic [COL_W-1:0]           beamCol,
  input  logic                       fgCur,
  input  logic [4:0]                 fgNbr,
  input  logic [NUM_PAL*3-1:0]       rowPal,
  input  logic [PAL_IDX_W-1:0]       cellPalIdx,
  input  logic [NUM_WIN-1:0]         winEnable,
  input  logic [NUM_WIN*ROW_W-1:0]   winStartRow,
  input  logic [NUM_WIN*ROW_W-1:0]   winEndRow,
  input  logic [NUM_WIN*COL_W-1:0]   winStartCol,
  input  logic [NUM_WIN*COL_W-1:0]   winEndCol,
  input  logic [NUM_WIN*3-1:0]       winColor,
  output logic [2:0]                 colOut,
  output logic [2:0]                 colOe,
  output logic                       fbkgOut,
  output logic                       fbkgOe,
  output logic                       htoneOut,
  output logic                       htoneOe
);

  ctrlStrobe_t stNow, stLate;
  logic winAny;
  logic [COLOR_W-1:0] winCol;

  osd_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .osdEn        (osdEn),
    .fbkgCharOnly (fbkgCharOnly),
    .edgeEn       (edgeEn),
    .edgeShadow   (edgeShadow),
    .stNow        (stNow),
    .stLate       (stLate)
  );

  osd_win_match #(
    .NUM_WIN (NUM_WIN),
    .ROW_W   (ROW_W),
    .COL_W   (COL_W)
  ) u_win (
    .beamRow     (beamRow),
    .beamCol     (beamCol),
    .winEnable   (winEnable),
    .winStartRow (winStartRow),
    .winEndRow   (winEndRow),
    .winStartCol (winStartCol),
    .winEndCol   (winEndCol),
    .winColor    (winColor),
    .winAny      (winAny),
    .winCol      (winCol)
  );

  osd_datapath #(
    .NUM_PAL   (NUM_PAL),
    .PAL_IDX_W (PAL_IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stNow      (stNow),
    .stLate     (stLate),
    .fgCur      (fgCur),
    .fgNbr      (fgNbr),
    .rowPal     (rowPal),
    .cellPalIdx (cellPalIdx),
    .winAny     (winAny),
    .winCol     (winCol),
    .colOut     (colOut),
    .colOe      (colOe),
    .fbkgOut    (fbkgOut),
    .fbkgOe     (fbkgOe),
    .htoneOut   (htoneOut),
    .htoneOe    (htoneOe)
  );

endmodule

// File: rtl/osd_compositor_chk.sv
module osd_compositor_chk #(
  parameter int NUM_WIN = 3,
  parameter int ROW_W   = 9,
  parameter int COL_W   = 9,
  parameter int NUM_PAL = 4,
  localparam int PAL_IDX_W = (NUM_PAL > 1) ? $clog2(NUM_PAL) : 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     osdEn,
  input logic                     fbkgCharOnly,
  input logic                     fgCur,
  input logic [NUM_PAL*3-1:0]     rowPal,
  input logic [PAL_IDX_W-1:0]     cellPalIdx,
  input logic [2:0]               colOut,
  input logic [2:0]               colOe,
  input logic                     fbkgOut,
  input logic                     fbkgOe,
  input logic                     htoneOut,
  input logic                     htoneOe
);

  logic [1:0] warm;
  logic [2:0] palSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warm <= 2'd0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  assign palSel = rowPal[int'(cellPalIdx)*3 +: 3];

  AST_DISABLED_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd2 && !$past(osdEn, 2)) |->
      (colOe == 3'b000 && !fbkgOe && !htoneOe && colOut == 3'b000)) // R3
    else $error("disabled display still drives");

  AST_FG_COLOR: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd2 && $past(osdEn, 2) && $past(fgCur, 2)) |->
      (colOut == $past(palSel, 2) && fbkgOut && fbkgOe && !htoneOut)) // R4
    else $error("foreground dot colour wrong");

  AST_HTONE_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    htoneOut |-> (fbkgOe && htoneOe && colOe == 3'b111)) // R10
    else $error("half-tone on an undriven dot");

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (colOe != 3'b000 && !fbkgOe) |-> (colOut == 3'b000 && !htoneOut)) // R12
    else $error("transparent dot not quiet");

  AST_CHARONLY_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd2 && $past(fbkgCharOnly, 2) && htoneOut) |-> !fbkgOut) // R11
    else $error("fast-blank high on window dot in char-only mode");

endmodule

bind osd_compositor osd_compositor_chk #(
  .NUM_WIN (NUM_WIN),
  .ROW_W   (ROW_W),
  .COL_W   (COL_W),
  .NUM_PAL (NUM_PAL)
) u_chk (.*);

// File: tb/osd_compositor_bench.sv
module osd_compositor_bench;

  localparam int NUM_WIN = 3;
  localparam int ROW_W   = 9;
  localparam int COL_W   = 9;
  localparam int NUM_PAL = 4;
  localparam int PAL_IDX_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic osdEn = 1'b0, fbkgCharOnly = 1'b0, edgeEn = 1'b0, edgeShadow = 1'b0;
  logic [ROW_W-1:0] beamRow = '0;
  logic [COL_W-1:0] beamCol = '0;
  logic fgCur = 1'b0;
  logic [4:0] fgNbr = '0;
  logic [NUM_PAL*3-1:0] rowPal;
  logic [PAL_IDX_W-1:0] cellPalIdx = '0;
  logic [NUM_WIN-1:0] winEnable;
  logic [NUM_WIN*ROW_W-1:0] winStartRow, winEndRow;
  logic [NUM_WIN*COL_W-1:0] winStartCol, winEndCol;
  logic [NUM_WIN*3-1:0] winColor;
  logic [2:0] colOut, colOe;
  logic fbkgOut, fbkgOe, htoneOut, htoneOe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         due;
    logic [2:0] col;
    logic [2:0] oe;
    logic       fb;
    logic       fbOe;
    logic       ht;
    logic       htOe;
    string      tag;
  } exp_t;

  exp_t expQ[$];

  osd_compositor #(
    .NUM_WIN (NUM_WIN), .ROW_W (ROW_W), .COL_W (COL_W), .NUM_PAL (NUM_PAL)
  ) u_osd_compositor (
    .clk (clk), .rstN (rstN), .osdEn (osdEn), .fbkgCharOnly (fbkgCharOnly),
    .edgeEn (edgeEn), .edgeShadow (edgeShadow), .beamRow (beamRow),
    .beamCol (beamCol), .fgCur (fgCur), .fgNbr (fgNbr), .rowPal (rowPal),
    .cellPalIdx (cellPalIdx), .winEnable (winEnable),
    .winStartRow (winStartRow), .winEndRow (winEndRow),
    .winStartCol (winStartCol), .winEndCol (winEndCol),
    .winColor (winColor), .colOut (colOut), .colOe (colOe),
    .fbkgOut (fbkgOut), .fbkgOe (fbkgOe), .htoneOut (htoneOut),
    .htoneOe (htoneOe)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // expected result from the requirements
  function automatic exp_t model(string tag);
    exp_t e;
    logic inWin, edgeDot;
    logic [2:0] wc;
    inWin = 1'b0;
    wc = 3'b000;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (!inWin && winEnable[i] &&
          beamRow >= winStartRow[i*ROW_W +: ROW_W] &&
          beamRow <= winEndRow[i*ROW_W +: ROW_W] &&
          beamCol >= winStartCol[i*COL_W +: COL_W] &&
          beamCol <= winEndCol[i*COL_W +: COL_W]) begin
        inWin = 1'b1;
        wc = winColor[i*3 +: 3];
      end
    end
    edgeDot = !fgCur && edgeEn &&
              (edgeShadow ? fgNbr[4] : (fgNbr[3:0] != 4'b0000));
    e.tag = tag;
    e.due = cyc + 2;
    if (!osdEn) begin
      e.col = 3'b000; e.oe = 3'b000; e.fb = 1'b0; e.fbOe = 1'b0;
      e.ht = 1'b0; e.htOe = 1'b0;
    end else begin
      e.oe = 3'b111; e.htOe = 1'b1;
      if (fgCur) begin
        e.col = rowPal[int'(cellPalIdx)*3 +: 3];
        e.fb = 1'b1; e.fbOe = 1'b1; e.ht = 1'b0;
      end else if (edgeDot) begin
        e.col = 3'b000; e.fb = 1'b1; e.fbOe = 1'b1; e.ht = 1'b0;
      end else if (inWin) begin
        e.col = wc; e.fb = !fbkgCharOnly; e.fbOe = 1'b1; e.ht = 1'b1;
      end else begin
        e.col = 3'b000; e.fb = 1'b0; e.fbOe = 1'b0; e.ht = 1'b0;
      end
    end
    return e;
  endfunction

  // driver: inputs already set just after a falling edge
  task automatic drive(string tag);
    expQ.push_back(model(tag));
    @(negedge clk);
  endtask

  task automatic compare(exp_t e);
    checks++;
    if (colOut !== e.col || colOe !== e.oe || fbkgOut !== e.fb ||
        fbkgOe !== e.fbOe || htoneOut !== e.ht || htoneOe !== e.htOe) begin
      errors++;
      $display("FAIL %s: got col=%b oe=%b fb=%b fbOe=%b ht=%b htOe=%b exp col=%b oe=%b fb=%b fbOe=%b ht=%b htOe=%b",
               e.tag, colOut, colOe, fbkgOut, fbkgOe, htoneOut, htoneOe,
               e.col, e.oe, e.fb, e.fbOe, e.ht, e.htOe);
    end
  endtask

  // monitor: pops items due in this cycle, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0 && expQ[0].due == cyc) compare(expQ.pop_front());
    end
  end

  task automatic checkQuiet(string tag);
    exp_t e;
    e.due = cyc; e.col = 3'b000; e.oe = 3'b000; e.fb = 1'b0; e.fbOe = 1'b0;
    e.ht = 1'b0; e.htOe = 1'b0; e.tag = tag;
    compare(e);
  endtask

  task automatic at(int r, int c);
    beamRow = ROW_W'(r);
    beamCol = COL_W'(c);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    rowPal = {3'b111, 3'b110, 3'b011, 3'b101};
    winEnable   = 3'b011;
    winStartRow = {9'd100, 9'd15, 9'd10};
    winEndRow   = {9'd110, 9'd40, 9'd20};
    winStartCol = {9'd100, 9'd20, 9'd10};
    winEndCol   = {9'd110, 9'd60, 9'd30};
    winColor    = {3'b100, 3'b010, 3'b001};
    osdEn = 1'b1; fgCur = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    checkQuiet("R1 during reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    checkQuiet("R1 first clock after reset");
    @(negedge clk);

    // R4 foreground palette slots outside windows
    osdEn = 1'b1; fgCur = 1'b1; at(200, 200);
    for (int k = 0; k < NUM_PAL; k++) begin
      cellPalIdx = PAL_IDX_W'(k);
      drive($sformatf("R4 fg slot %0d", k));
    end
    at(12, 12); cellPalIdx = 2'd2; drive("R4 fg inside window");

    // R5 border mode, each direct neighbour alone
    fgCur = 1'b0; edgeEn = 1'b1; edgeShadow = 1'b0; at(200, 200);
    for (int b = 0; b < 4; b++) begin
      fgNbr = 5'b00001 << b;
      drive($sformatf("R5 border nbr %0d", b));
    end
    at(12, 12); fgNbr = 5'b00100; drive("R5 border inside window");
    at(200, 200); fgNbr = 5'b10000; drive("R6 upper-left ignored in border mode");

    // R6 shadow mode
    edgeShadow = 1'b1;
    fgNbr = 5'b10000; drive("R6 shadow upper-left");
    fgNbr = 5'b01111; drive("R6 direct nbrs ignored in shadow");
    at(12, 12); fgNbr = 5'b00001; drive("R6 shadow ignored nbr in window");

    // R7 outline disabled
    edgeEn = 1'b0; edgeShadow = 1'b0; at(200, 200); fgNbr = 5'b11111;
    drive("R7 no outline when off");
    at(12, 12); drive("R7 window shows through");
    fgNbr = 5'b00000;

    // R8 inclusive bounds of window 0
    at(10, 10); drive("R8 corner start");
    at(20, 14); drive("R8 last row");
    at(9, 12);  drive("R8 row above");
    at(12, 31); drive("R8 column past end");
    at(14, 30); drive("R8 last column");

    // R9 overlap
    at(16, 25); drive("R9 overlap lowest index");
    at(16, 31); drive("R9 second window only");
    at(41, 25); drive("R9 below second window");

    // R13 disabled window
    at(105, 105); drive("R13 disabled window ignored");
    winEnable = 3'b111; drive("R13 window enabled");
    winEnable = 3'b010; at(12, 12); drive("R13 window 0 off");
    winEnable = 3'b011;

    // R10 / R11 half-tone and fast-blank modes
    fbkgCharOnly = 1'b1; at(16, 25); drive("R11 char-only window dot");
    fgCur = 1'b1; drive("R11 char-only fg dot");
    fgCur = 1'b0; edgeEn = 1'b1; fgNbr = 5'b00010; drive("R10 outline in window no half-tone");
    fgNbr = 5'b00000; edgeEn = 1'b0; fbkgCharOnly = 1'b0; drive("R10 window dot half-tone");
    at(300, 300); drive("R12 transparent dot");

    // R3 display disabled
    osdEn = 1'b0; fgCur = 1'b1; drive("R3 disabled fg");
    fgCur = 1'b0; at(16, 25); drive("R3 disabled window");
    osdEn = 1'b1;

    // R2 inputs changing every cycle
    for (int n = 0; n < 24; n++) begin
      fgCur = n[0];
      cellPalIdx = PAL_IDX_W'(n >> 1);
      osdEn = (n % 5) != 3;
      fbkgCharOnly = n[2];
      at(8 + n, 8 + 2 * n);
      drive($sformatf("R2 stream %0d", n));
    end

    repeat (4) @(negedge clk);
    summary();
  end

endmodule